// File: doc/BRIEF.md
# Next Program-Address Unit

This block holds the program counter of a 32-bit instruction stream and, every clock, decides where the stream goes next. Each cycle it forms three candidate addresses from the current counter value and the instruction word in flight: the sequential address (counter plus four bytes), a PC-relative branch destination, and a region-local jump destination. It then loads one of them into the counter register.

The decoder supplies two flags, one for a conditional branch-on-equal and one for an unconditional jump, together with the two register operands that the branch compares. A control module turns the flags and the equality result into a small set of select strobes. A datapath module owns the two adders, the comparator, the three-way selection and the counter register. Instruction fetch, operand reads and arithmetic are the job of neighbouring blocks.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, the counter is loaded with 0; `pcOut` shows 0 after that edge.
- R2: With neither `isBranch` nor `isJump` set, `pcOut` after the edge equals its previous value plus 4, whatever the instruction and operands are.
- R3: With `isBranch` set, `isJump` clear and `rsVal` equal to `rtVal`, the new `pcOut` is (old `pcOut` + 4) + (instrWord[15:0] sign-extended and multiplied by 4).
- R4: With `isBranch` set, `isJump` clear and `rsVal` different from `rtVal`, the new `pcOut` is old `pcOut` + 4.
- R5: The 16-bit branch offset in instrWord[15:0] is two's complement, so an offset with bit 15 set moves the counter backwards from old `pcOut` + 4.
- R6: With `isJump` set, the new `pcOut` is bits [31:28] of (old `pcOut` + 4), followed by instrWord[25:0], followed by two zero bits.
- R7: When `isJump` and `isBranch` are both set, the jump destination of R6 is taken regardless of the operands.
- R8: All address arithmetic is modulo 2^32: 0xFFFFFFFC plus 4 gives 0, and a jump from 0x0FFFFFFC takes its upper four bits from 0x10000000.
- R9: Outside reset, bits [1:0] of `pcOut` are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| instrWord | input | 32 | Instruction at the current counter value |
| rsVal | input | 32 | First comparison operand |
| rtVal | input | 32 | Second comparison operand |
| isBranch | input | 1 | Decoded branch-on-equal |
| isJump | input | 1 | Decoded unconditional jump |
| pcOut | output | 32 | Registered program counter |

## Verification
On every cycle the assertions relate the counter to its previous value and the previous inputs: the sequential step, taken and untaken branches, the jump destination with the priority over a branch, the reset load and word alignment. What they cannot show is the reachability of the interesting addresses, so the bench steers the counter with directed sequences into backward branches, the wrap from 0xFFFFFFFC to 0 and a jump whose region bits come from the carry into bit 28, and mixes in seeded random flag, operand and offset patterns with forced operand equality.

// File: rtl/pc_next_pkg.sv
`timescale 1ns/1ps
package pc_next_pkg;

  // Source of the next counter value, chosen by the control module.
  typedef enum logic [1:0] {
    SRC_SEQ    = 2'd0,
    SRC_BRANCH = 2'd1,
    SRC_JUMP   = 2'd2
  } nextSrc_t;

  // Strobes from control to datapath.
  typedef struct packed {
    nextSrc_t src;
    logic     loadReset;
  } pcStrobes_t;

endpackage

// File: rtl/pc_next_ctrl.sv
`timescale 1ns/1ps
module pc_next_ctrl
  import pc_next_pkg::*;
(
  input  logic       rst,
  input  logic       isBranch,
  input  logic       isJump,
  input  logic       operandsEqual,
  output pcStrobes_t strobes
);

  always_comb begin
    strobes.loadReset = rst;
    // Jump wins over branch; a branch only counts when the operands match.
    if (isJump) begin
      strobes.src = SRC_JUMP;
    end else if (isBranch && operandsEqual) begin
      strobes.src = SRC_BRANCH;
    end else begin
      strobes.src = SRC_SEQ;
    end
  end

endmodule

// File: rtl/pc_next_datapath.sv
`timescale 1ns/1ps
module pc_next_datapath
  import pc_next_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int INSTR_W = 32,
  parameter int OFF_W   = 16,
  parameter int IDX_W   = 26,
  parameter int STEP    = 4
) (
  input  logic               clk,
  input  pcStrobes_t         strobes,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [DATA_W-1:0]  rsVal,
  input  logic [DATA_W-1:0]  rtVal,
  output logic               operandsEqual,
  output logic [ADDR_W-1:0]  pcOut
);

  localparam int ALIGN_W  = $clog2(STEP);
  localparam int REGION_W = ADDR_W - IDX_W - ALIGN_W;
  localparam int EXT_W    = ADDR_W - OFF_W - ALIGN_W;

  logic [ADDR_W-1:0] pcReg;
  logic [ADDR_W-1:0] pcSeq;
  logic [ADDR_W-1:0] branchDisp;
  logic [ADDR_W-1:0] branchTarget;
  logic [ADDR_W-1:0] jumpTarget;
  logic [ADDR_W-1:0] pcNext;
  logic [OFF_W-1:0]  offsetField;
  logic [IDX_W-1:0]  indexField;

  assign offsetField = instrWord[OFF_W-1:0];
  assign indexField  = instrWord[IDX_W-1:0];

  // Sequential adder.
  assign pcSeq = pcReg + ADDR_W'(STEP);

  // Dedicated branch adder: displacement in words, relative to pcSeq.
  assign branchDisp   = {{EXT_W{offsetField[OFF_W-1]}}, offsetField, {ALIGN_W{1'b0}}};
  assign branchTarget = pcSeq + branchDisp;

  // Region-local jump keeps the top bits of the sequential address.
  generate
    if (REGION_W > 0) begin : g_region
      assign jumpTarget = {pcSeq[ADDR_W-1 -: REGION_W], indexField, {ALIGN_W{1'b0}}};
    end else begin : g_noRegion
      assign jumpTarget = {indexField[ADDR_W-ALIGN_W-1:0], {ALIGN_W{1'b0}}};
    end
  endgenerate

  assign operandsEqual = (rsVal == rtVal);

  always_comb begin
    unique case (strobes.src)
      SRC_BRANCH: pcNext = branchTarget;
      SRC_JUMP:   pcNext = jumpTarget;
      default:    pcNext = pcSeq;
    endcase
  end

  always_ff @(posedge clk) begin
    if (strobes.loadReset) begin
      pcReg <= '0;
    end else begin
      pcReg <= pcNext;
    end
  end

  assign pcOut = pcReg;

endmodule

// File: rtl/pc_next_unit.sv
`timescale 1ns/1ps
module pc_next_unit
  import pc_next_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int INSTR_W = 32,
  parameter int OFF_W   = 16,
  parameter int IDX_W   = 26,
  parameter int STEP    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [DATA_W-1:0]  rsVal,
  input  logic [DATA_W-1:0]  rtVal,
  input  logic               isBranch,
  input  logic               isJump,
  output logic [ADDR_W-1:0]  pcOut
);

  pcStrobes_t strobes;
  logic       operandsEqual;

  pc_next_ctrl u_ctrl (
    .rst           (rst),
    .isBranch      (isBranch),
    .isJump        (isJump),
    .operandsEqual (operandsEqual),
    .strobes       (strobes)
  );

  pc_next_datapath #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .INSTR_W (INSTR_W),
    .OFF_W   (OFF_W),
    .IDX_W   (IDX_W),
    .STEP    (STEP)
  ) u_dp (
    .clk           (clk),
    .strobes       (strobes),
    .instrWord     (instrWord),
    .rsVal         (rsVal),
    .rtVal         (rtVal),
    .operandsEqual (operandsEqual),
    .pcOut         (pcOut)
  );

endmodule

// File: rtl/pc_next_checker.sv
`timescale 1ns/1ps
module pc_next_checker #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int INSTR_W = 32,
  parameter int OFF_W   = 16,
  parameter int IDX_W   = 26
) (
  input logic               clk,
  input logic               rst,
  input logic [INSTR_W-1:0] instrWord,
  input logic [DATA_W-1:0]  rsVal,
  input logic [DATA_W-1:0]  rtVal,
  input logic               isBranch,
  input logic               isJump,
  input logic [ADDR_W-1:0]  pcOut
);

  localparam int REGION_W = ADDR_W - IDX_W - 2;

  logic [ADDR_W-1:0] seqAddr;
  logic [ADDR_W-1:0] takenAddr;
  assign seqAddr   = pcOut + ADDR_W'(4);
  assign takenAddr = seqAddr + ADDR_W'({{(ADDR_W-OFF_W){instrWord[OFF_W-1]}}, instrWord[OFF_W-1:0]} <<< 2);

  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> pcOut == '0);

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!isBranch && !isJump) |=> pcOut == $past(seqAddr));

  assert_branch_taken_R3: assert property (@(posedge clk) disable iff (rst)
    (isBranch && !isJump && rsVal == rtVal) |=> pcOut == $past(takenAddr));

  assert_branch_untaken_R4: assert property (@(posedge clk) disable iff (rst)
    (isBranch && !isJump && rsVal != rtVal) |=> pcOut == $past(seqAddr));

  assert_jump_index_R6: assert property (@(posedge clk) disable iff (rst)
    isJump |=> (pcOut[IDX_W+1:2] == $past(instrWord[IDX_W-1:0]))
               && (pcOut[ADDR_W-1 -: REGION_W] == $past(seqAddr[ADDR_W-1 -: REGION_W])));

  // R7: jump target holds even with the branch flag up and equal operands.
  assert_jump_priority_R7: assert property (@(posedge clk) disable iff (rst)
    (isJump && isBranch) |=> pcOut[1:0] == 2'b00 && pcOut[IDX_W+1:2] == $past(instrWord[IDX_W-1:0]));

  assert_aligned_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) || pcOut[1:0] == 2'b00);

endmodule

bind pc_next_unit pc_next_checker #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .INSTR_W (INSTR_W),
  .OFF_W   (OFF_W),
  .IDX_W   (IDX_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .instrWord (instrWord),
  .rsVal     (rsVal),
  .rtVal     (rtVal),
  .isBranch  (isBranch),
  .isJump    (isJump),
  .pcOut     (pcOut)
);

// File: tb/sim_pc_next_unit.sv
`timescale 1ns/1ps
module sim_pc_next_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] instrWord;
  logic [31:0] rsVal;
  logic [31:0] rtVal;
  logic        isBranch;
  logic        isJump;
  logic [31:0] pcOut;

  int compared   = 0;
  int mismatched = 0;
  bit finished   = 1'b0;
  logic [31:0] expPc;

  always #2.5 clk = ~clk;

  pc_next_unit u0 (
    .clk(clk), .rst(rst), .instrWord(instrWord), .rsVal(rsVal), .rtVal(rtVal),
    .isBranch(isBranch), .isJump(isJump), .pcOut(pcOut)
  );

  function automatic logic [31:0] modelNext(logic [31:0] pc, logic br, logic jp,
                                            logic [31:0] ins, logic [31:0] a, logic [31:0] b);
    logic [31:0] seq;
    seq = pc + 32'd4;
    if (jp) return {seq[31:28], ins[25:0], 2'b00};
    if (br && a == b) return seq + {{14{ins[15]}}, ins[15:0], 2'b00};
    return seq;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive at the falling edge, clock once, sample at the next falling edge.
  task automatic step(string tag, logic br, logic jp, logic [31:0] ins,
                      logic [31:0] a, logic [31:0] b);
    isBranch = br; isJump = jp; instrWord = ins; rsVal = a; rtVal = b;
    expPc = modelNext(expPc, br, jp, ins, a, b);
    @(posedge clk);
    @(negedge clk);
    check(tag, pcOut, expPc);
    check("R9 alignment", {30'd0, pcOut[1:0]}, 32'd0);
  endtask

  task automatic doReset();
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 reset", pcOut, 32'd0);
    rst = 1'b0;
    expPc = 32'd0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; isBranch = 1'b0; isJump = 1'b0;
    instrWord = '0; rsVal = '0; rtVal = '0; expPc = '0;
    @(negedge clk);
    doReset();

    // R2: sequential steps with garbage in the instruction and operands.
    step("R2 seq", 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h1, 32'h1);
    step("R2 seq", 1'b0, 1'b0, 32'h0000_8000, 32'h5, 32'h6);
    // R3: forward branch taken, offset 3 words from 0x0C -> 0x18.
    step("R3 forward taken", 1'b1, 1'b0, 32'h0000_0003, 32'hA5, 32'hA5);
    // R4: unequal operands fall through.
    step("R4 untaken", 1'b1, 1'b0, 32'h0000_0100, 32'hA5, 32'hA4);
    // R5: backward branch by one word lands on the branch itself.
    step("R5 backward", 1'b1, 1'b0, 32'h0000_FFFF, 32'h0, 32'h0);
    // R6: jump to index 0x40.
    step("R6 jump", 1'b0, 1'b1, 32'h0000_0040, 32'h0, 32'h1);
    // R7: jump beats a branch with equal operands.
    step("R7 priority", 1'b1, 1'b1, 32'h0000_0010, 32'h7, 32'h7);

    // R8: wrap down below zero then back to zero.
    doReset();
    step("R8 wrap below", 1'b1, 1'b0, 32'h0000_FFFE, 32'h9, 32'h9);
    check("R8 wrap value", pcOut, 32'hFFFF_FFFC);
    step("R8 wrap to zero", 1'b0, 1'b0, 32'h0, 32'h0, 32'h0);
    check("R8 zero value", pcOut, 32'h0);
    // R8: region carry into bit 28 for the jump.
    step("R6 jump top", 1'b0, 1'b1, 32'h03FF_FFFF, 32'h0, 32'h0);
    step("R8 region carry", 1'b0, 1'b1, 32'h0000_0000, 32'h0, 32'h0);
    check("R8 region value", pcOut, 32'h1000_0000);

    // Random mix with a fixed seed.
    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ins, a, b;
      logic br, jp;
      string tag;
      ins = $urandom();
      a   = $urandom();
      b   = ($urandom() % 2 == 0) ? a : $urandom();
      br  = ($urandom() % 2 == 0);
      jp  = ($urandom() % 5 == 0);
      if (jp && br)      tag = "R7 random";
      else if (jp)       tag = "R6 random";
      else if (!br)      tag = "R2 random";
      else if (a != b)   tag = "R4 random";
      else if (ins[15])  tag = "R5 random";
      else               tag = "R3 random";
      step(tag, br, jp, ins, a, b);
    end

    doReset();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule